// File: doc/BRIEF.md
# Reset Cause and Supply Status Register

This block is one byte-wide control/status register that tells software why the system last came out of reset, and reports the health of the supply and of the clock synthesizer. Hardware sets the reset-cause flags from one-cycle event pulses. A watchdog event and a low-voltage event each have their own pulse. Software then reads or clears the flags through a simple strobe-based CPU port. Each flag has its own clearing rule. The watchdog flag is cleared by writing zero to it. The low-voltage flag is cleared by reading the register. The live status bits cannot be cleared by software at all.

The low-voltage flag is not disturbed by later watchdog or external resets. Because of this, the first failure stays on record. Together the two flags decode the reset cause: both clear means an external reset, watchdog flag alone means a watchdog reset, and the low-voltage flag set means a low-voltage reset. A supply-warning interrupt is latched on each rising edge of the warning level while the interrupt enable bit is set. The request is dropped by an acknowledge pulse from the CPU. The block's own registers are cleared only by the power-on reset input.

Top module: `rst_cause_stat`

## Requirements
- R1: `rdData` bits 7:5 always read 0. Bit 4 is the watchdog flag, bit 3 the clock-locked bit, bit 2 the low-voltage flag, bit 1 the supply-warning bit and bit 0 the interrupt enable.
- R2: A `wdtRstPulse` with no `lvRstPulse` in the same cycle makes bit 4 read 1 from the next cycle onward.
- R3: A write with `wrData[4]`=0 clears bit 4 on the next cycle. A write with `wrData[4]`=1 leaves bit 4 unchanged. A `wdtRstPulse` in the same cycle as a clearing write leaves bit 4 at 1.
- R4: A `lvRstPulse` clears bit 4 on the next cycle, even if `wdtRstPulse` is high in the same cycle.
- R5: A `lvRstPulse` while `lvdDisable`=0 makes bit 2 read 1 from the next cycle onward. Watchdog pulses and writes do not change bit 2.
- R6: A read (`rdStb`=1) returns the current bit 2 in the same cycle and clears it on the next cycle. If `lvRstPulse` arrives in the same cycle as the read, bit 2 stays 1.
- R7: While `lvdDisable`=1, bit 2 reads 0, the stored flag is cleared, and `lvRstPulse` has no effect.
- R8: Bit 3 equals `clkLocked` and bit 1 equals `supplyLow` in every cycle. Writes have no effect on either bit.
- R9: A write loads `wrData[0]` into bit 0, and it is read back from the next cycle onward.
- R10: A 0-to-1 transition of `supplyLow` between consecutive clock edges while bit 0 is 1 sets `irqReq` on the next cycle. The request then holds until acknowledged. No request is raised for an edge seen while bit 0 is 0.
- R11: An `irqAck` pulse clears `irqReq` on the next cycle, unless a new qualifying edge of `supplyLow` occurs in that same cycle.
- R12: After power-on reset, bits 4, 2 and 0 read 0 and `irqReq` is 0. Bits 3 and 1 reflect their inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, active low, asynchronous |
| wdtRstPulse | input | 1 | One-cycle pulse: a watchdog reset occurred |
| lvRstPulse | input | 1 | One-cycle pulse: a low-voltage reset occurred |
| supplyLow | input | 1 | Level: supply below the warning threshold |
| clkLocked | input | 1 | Level: clock synthesizer at operating frequency |
| lvdDisable | input | 1 | Option: low-voltage detection disabled |
| rdStb | input | 1 | CPU read strobe |
| wrStb | input | 1 | CPU write strobe |
| wrData | input | DATA_W | CPU write data |
| irqAck | input | 1 | Interrupt acknowledge pulse |
| rdData | output | DATA_W | Register read value |
| irqReq | output | 1 | Supply-warning interrupt request |

## Verification
The bench builds the block with the default `DATA_W` of 8. At that width the field positions are fixed, and the random phase can reach every one of the 256 write values, including those that touch the reserved bits. The directed phase forces the same-cycle collisions that decide priority:
- a watchdog pulse against a clearing write;
- a low-voltage pulse against a watchdog pulse, and against a read;
- a new warning edge against an acknowledge.

The random phase then mixes all inputs freely. Because of this mixing, the option input can toggle while the low-voltage flag is set.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  localparam int BIT_IE   = 0;
  localparam int BIT_WARN = 1;
  localparam int BIT_LV   = 2;
  localparam int BIT_LOCK = 3;
  localparam int BIT_WD   = 4;
  localparam int USED_W   = 5;

  typedef struct packed {
    logic wdSet;
    logic wdClr;
    logic lvSet;
    logic lvClr;
    logic lvKill;
    logic ieWr;
    logic ieVal;
    logic irqSet;
    logic irqClr;
  } rcsStrobes_t;
endpackage

// File: rtl/rcs_ctrl.sv
module rcs_ctrl
  import rcs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              wdtRstPulse,
  input  logic              lvRstPulse,
  input  logic              lvdDisable,
  input  logic              supplyLow,
  input  logic              rdStb,
  input  logic              wrStb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              irqAck,
  input  logic              ieCur,
  output rcsStrobes_t       stb
);
  logic supPrev;
  logic supRise;
  logic unusedWrBits;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) supPrev <= 1'b0;
    else          supPrev <= supplyLow;
  end

  assign supRise      = supplyLow & ~supPrev;
  assign unusedWrBits = ^wrData;

  always_comb begin
    stb        = '0;
    stb.wdSet  = wdtRstPulse & ~lvRstPulse;
    stb.wdClr  = lvRstPulse | (wrStb & ~wrData[BIT_WD]);
    stb.lvKill = lvdDisable;
    stb.lvSet  = lvRstPulse & ~lvdDisable;
    stb.lvClr  = rdStb;
    stb.ieWr   = wrStb;
    stb.ieVal  = wrData[BIT_IE];
    stb.irqSet = supRise & ieCur;
    stb.irqClr = irqAck;
  end
endmodule

// File: rtl/rcs_dpath.sv
module rcs_dpath
  import rcs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              porRstN,
  input  rcsStrobes_t       stb,
  input  logic              clkLocked,
  input  logic              supplyLow,
  output logic [DATA_W-1:0] rdData,
  output logic              ieCur,
  output logic              irqReq
);
  localparam int RSV_W = DATA_W - USED_W;

  logic wdFlag, lvFlag, ieBit, irqPend;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      wdFlag  <= 1'b0;
      lvFlag  <= 1'b0;
      ieBit   <= 1'b0;
      irqPend <= 1'b0;
    end else begin
      if (stb.wdSet)      wdFlag <= 1'b1;
      else if (stb.wdClr) wdFlag <= 1'b0;

      if (stb.lvKill)     lvFlag <= 1'b0;
      else if (stb.lvSet) lvFlag <= 1'b1;
      else if (stb.lvClr) lvFlag <= 1'b0;

      if (stb.ieWr)       ieBit <= stb.ieVal;

      if (stb.irqSet)      irqPend <= 1'b1;
      else if (stb.irqClr) irqPend <= 1'b0;
    end
  end

  generate
    if (RSV_W > 0) begin : g_rsv
      assign rdData[DATA_W-1:USED_W] = '0;
    end
  endgenerate

  assign rdData[BIT_WD]   = wdFlag;
  assign rdData[BIT_LOCK] = clkLocked;
  assign rdData[BIT_LV]   = lvFlag & ~stb.lvKill;
  assign rdData[BIT_WARN] = supplyLow;
  assign rdData[BIT_IE]   = ieBit;
  assign ieCur            = ieBit;
  assign irqReq           = irqPend;
endmodule

// File: rtl/rst_cause_stat.sv
module rst_cause_stat
  import rcs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              wdtRstPulse,
  input  logic              lvRstPulse,
  input  logic              supplyLow,
  input  logic              clkLocked,
  input  logic              lvdDisable,
  input  logic              rdStb,
  input  logic              wrStb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              irqAck,
  output logic [DATA_W-1:0] rdData,
  output logic              irqReq
);
  rcsStrobes_t stb;
  logic        ieCur;

  rcs_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .porRstN(porRstN), .wdtRstPulse(wdtRstPulse),
    .lvRstPulse(lvRstPulse), .lvdDisable(lvdDisable), .supplyLow(supplyLow),
    .rdStb(rdStb), .wrStb(wrStb), .wrData(wrData), .irqAck(irqAck),
    .ieCur(ieCur), .stb(stb)
  );

  rcs_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .porRstN(porRstN), .stb(stb), .clkLocked(clkLocked),
    .supplyLow(supplyLow), .rdData(rdData), .ieCur(ieCur), .irqReq(irqReq)
  );
endmodule

// File: rtl/rcs_check.sv
module rcs_check #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              porRstN,
  input logic              wdtRstPulse,
  input logic              lvRstPulse,
  input logic              supplyLow,
  input logic              clkLocked,
  input logic              lvdDisable,
  input logic              rdStb,
  input logic              wrStb,
  input logic [DATA_W-1:0] wrData,
  input logic              irqAck,
  input logic [DATA_W-1:0] rdData,
  input logic              irqReq
);
  p_rsv_zero_r1: assert property (@(posedge clk) disable iff (!porRstN)
    rdData[DATA_W-1:5] == '0);

  p_wd_set_r2: assert property (@(posedge clk) disable iff (!porRstN)
    (wdtRstPulse && !lvRstPulse) |=> rdData[4]);

  p_wd_lvclr_r4: assert property (@(posedge clk) disable iff (!porRstN)
    lvRstPulse |=> !rdData[4]);

  p_lv_keep_r5: assert property (@(posedge clk) disable iff (!porRstN)
    (rdData[2] && !rdStb) |=> (rdData[2] || lvdDisable));

  p_lv_rdclr_r6: assert property (@(posedge clk) disable iff (!porRstN)
    (rdStb && !lvRstPulse) |=> !rdData[2]);

  p_lv_off_r7: assert property (@(posedge clk) disable iff (!porRstN)
    lvdDisable |-> !rdData[2]);

  p_live_bits_r8: assert property (@(posedge clk) disable iff (!porRstN)
    (rdData[3] == clkLocked) && (rdData[1] == supplyLow));

  p_ie_wr_r9: assert property (@(posedge clk) disable iff (!porRstN)
    wrStb |=> (rdData[0] == $past(wrData[0])));

  p_irq_ack_r11: assert property (@(posedge clk) disable iff (!porRstN)
    (irqAck && !supplyLow) |=> !irqReq);
endmodule

bind rst_cause_stat rcs_check #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .porRstN(porRstN), .wdtRstPulse(wdtRstPulse),
  .lvRstPulse(lvRstPulse), .supplyLow(supplyLow), .clkLocked(clkLocked),
  .lvdDisable(lvdDisable), .rdStb(rdStb), .wrStb(wrStb), .wrData(wrData),
  .irqAck(irqAck), .rdData(rdData), .irqReq(irqReq)
);

// File: tb/rst_cause_stat_test.sv
module rst_cause_stat_test;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 8;
  localparam int WDOG_LIMIT = 100000;

  logic clk = 1'b0, porRstN = 1'b0;
  logic wdtRstPulse = 0, lvRstPulse = 0, supplyLow = 0, clkLocked = 1;
  logic lvdDisable = 0, rdStb = 0, wrStb = 0, irqAck = 0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic irqReq;

  int nChecks = 0, nFails = 0;
  bit done = 0;
  logic mWd = 0, mLv = 0, mIe = 0, mIrq = 0, mPrev = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_cause_stat #(.DATA_W(DATA_W)) uut (
    .clk(clk), .porRstN(porRstN), .wdtRstPulse(wdtRstPulse),
    .lvRstPulse(lvRstPulse), .supplyLow(supplyLow), .clkLocked(clkLocked),
    .lvdDisable(lvdDisable), .rdStb(rdStb), .wrStb(wrStb), .wrData(wrData),
    .irqAck(irqAck), .rdData(rdData), .irqReq(irqReq)
  );

  function automatic logic [DATA_W-1:0] expRd();
    logic [DATA_W-1:0] v = '0;
    v[4] = mWd; v[3] = clkLocked; v[2] = mLv & ~lvdDisable;
    v[1] = supplyLow; v[0] = mIe;
    return v;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic modelEdge();
    logic nWd = mWd, nLv = mLv, nIrq;
    if (lvRstPulse) nWd = 0;
    else if (wdtRstPulse) nWd = 1;
    else if (wrStb && !wrData[4]) nWd = 0;
    if (lvdDisable) nLv = 0;
    else if (lvRstPulse) nLv = 1;
    else if (rdStb) nLv = 0;
    nIrq = (supplyLow && !mPrev && mIe) ? 1'b1 : (irqAck ? 1'b0 : mIrq);
    if (wrStb) mIe = wrData[0];
    mWd = nWd; mLv = nLv; mIrq = nIrq; mPrev = supplyLow;
  endtask

  task automatic step(string tag, logic wdt, logic lvp, logic sl, logic lk,
                      logic dis, logic rd, logic wr, logic [DATA_W-1:0] wd,
                      logic ack);
    @(negedge clk);
    wdtRstPulse = wdt; lvRstPulse = lvp; supplyLow = sl; clkLocked = lk;
    lvdDisable = dis; rdStb = rd; wrStb = wr; wrData = wd; irqAck = ack;
    #1 check({tag, " pre-edge read"}, rdData, expRd());
    @(posedge clk);
    modelEdge();
    #1;
    check({tag, " rdData"}, rdData, expRd());
    check({tag, " irqReq"}, irqReq, mIrq);
  endtask

  task automatic idle(string tag, logic sl);
    step(tag, 0, 0, sl, 1, 0, 0, 0, '0, 0);
  endtask

  initial begin
    repeat (WDOG_LIMIT) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    porRstN = 1'b1;
    #1;
    check("R12 reset value", rdData, 32'h08);
    check("R12 reset irq", irqReq, 0);
    check("R1 reserved zero", rdData[7:5], 0);

    step("R2 wdt pulse", 1, 0, 0, 1, 0, 0, 0, '0, 0);
    check("R2 bit4 set", rdData[4], 1);
    step("R9 R3 write ones", 0, 0, 0, 1, 0, 0, 1, 8'hFF, 0);
    check("R3 write one keeps bit4", rdData[4], 1);
    check("R9 ie set", rdData[0], 1);
    check("R8 live bits ignore write", {rdData[3], rdData[1]}, 2'b10);
    check("R1 reserved after write", rdData[7:5], 0);
    step("R3 write zero", 0, 0, 0, 0, 0, 0, 1, 8'h01, 0);
    check("R3 bit4 cleared", rdData[4], 0);
    check("R8 lock follows", rdData[3], 0);
    step("R3 set beats clear", 1, 0, 0, 1, 0, 0, 1, 8'h01, 0);
    check("R3 bit4 set wins", rdData[4], 1);
    step("R4 R5 lv with wdt", 1, 1, 0, 1, 0, 0, 0, '0, 0);
    check("R4 bit4 cleared by lv", rdData[4], 0);
    check("R5 bit2 set", rdData[2], 1);
    step("R5 lv survives wdt", 1, 0, 0, 1, 0, 0, 1, 8'h11, 0);
    check("R5 bit2 kept", rdData[2], 1);
    step("R6 read with lv pulse", 0, 1, 0, 1, 0, 1, 0, '0, 0);
    check("R6 set wins over read", rdData[2], 1);
    step("R6 read clears", 0, 0, 0, 1, 0, 1, 0, '0, 0);
    check("R6 bit2 cleared", rdData[2], 0);
    step("R7 pulse while disabled", 0, 1, 0, 1, 1, 0, 0, '0, 0);
    check("R7 bit2 zero", rdData[2], 0);
    step("R7 set", 0, 1, 0, 1, 0, 0, 0, '0, 0);
    step("R7 disable masks", 0, 0, 0, 1, 1, 0, 0, '0, 0);
    check("R7 masked", rdData[2], 0);
    step("R7 reenable", 0, 0, 0, 1, 0, 0, 0, '0, 0);
    check("R7 stored flag cleared", rdData[2], 0);

    step("R9 ie on", 0, 0, 0, 1, 0, 0, 1, 8'h01, 0);
    step("R10 warn rise", 0, 0, 1, 1, 0, 0, 0, '0, 0);
    check("R10 irq raised", irqReq, 1);
    idle("R10 irq held", 1);
    check("R10 irq still set", irqReq, 1);
    step("R11 ack", 0, 0, 1, 1, 0, 0, 0, '0, 1);
    check("R11 ack clears", irqReq, 0);
    idle("R11 warn low", 0);
    step("R11 rise with ack", 0, 0, 1, 1, 0, 0, 0, '0, 1);
    check("R11 new edge wins", irqReq, 1);
    step("R11 ack again", 0, 0, 0, 1, 0, 0, 1, 8'h00, 1);
    step("R10 rise ie off", 0, 0, 1, 1, 0, 0, 0, '0, 0);
    check("R10 no irq when disabled", irqReq, 0);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r = $urandom;
      step("R1 random", r[3:0] == 0, r[7:4] == 0, r[8], r[9] | r[10],
           r[14:11] == 0, r[15], r[16] & r[17], r[25:18], r[26] & r[27]);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule